// File: doc/BRIEF.md
# SD Card Single-Block Read Host

This block is a hardware host that reads data blocks from an SD or SDHC card over the card's serial mode. The card sees four wires: a host-driven serial clock, an active-low select, a host-to-card command line and a card-to-host data line. All transfers move whole bytes, most significant bit first. The first request after reset makes the block bring the card up. It sends a run of idle clocks, then a software-reset command, then the application-command pair that starts the card's internal initialization. It repeats that pair until the card reports ready. After that, each request issues one block-read command.

Every outgoing command is a six-byte frame. The host computes the frame's CRC7 itself, then hunts a bounded number of byte times for the card's reply. After an accepted read reply it waits for the data start token. It then passes the 512 payload bytes to a valid/ready byte stream, flagging the last byte, and clocks in and drops the two block CRC bytes. The stream obeys back-pressure: a byte that has been offered stays unchanged until it is taken, and the serial clock stops while the consumer stalls. The card-type flag picks the read argument. A standard-capacity card gets a byte address and a high-capacity card gets the block number.

Top module: `sd_block_reader`

## Requirements
- R1: After reset, `busy`, `error` and `m_valid` are low, `sd_cs_n` and `sd_cmd` are high, and `sd_clk` is low.
- R2: `sd_clk` idles low and each of its phases lasts CLK_HALF cycles. The host changes `sd_cmd` only while `sd_clk` is low and samples `sd_dat` as `sd_clk` rises. Bytes go out and come in MSB first, and `sd_cmd` rests high when no command byte is being sent.
- R3: A command frame is six bytes: `01` followed by the 6-bit command index, then the 32-bit argument MSB first, then a byte that holds the CRC7 (polynomial x^7+x^3+1, computed over the first 40 bits) in bits 7:1 with bit 0 set to 1. The reset command's last byte is therefore 0x95.
- R4: When the card is not yet initialized, an accepted start first sends PWR_BYTES×8 (80) clocks with `sd_cs_n` high and `sd_cmd` high. It then lowers `sd_cs_n` and sends index 0 with argument 0, which must be answered 0x01. Next it sends index 55 (answer 0x00 or 0x01), then index 41 with argument bit 30 equal to `high_cap`. An answer of 0x01 to index 41 repeats the 55/41 pair up to INIT_TRIES times, and 0x00 completes initialization. Any other answer, or running out of tries, ends the request with `error`.
- R5: The read command is index 17. Its argument is `blk_addr` when `high_cap` is 1, and `blk_addr`×512 truncated to 32 bits when it is 0.
- R6: After a frame the host reads at most RESP_BYTES (8) bytes. The first byte with bit 7 low is the reply. If none of the 8 has bit 7 low, the request ends with `error`. A read needs the reply 0x00.
- R7: After the read reply, 0xFF bytes are skipped, up to TOKEN_BYTES of them. 0xFE starts the data. Any other byte, or running out of the allowance, ends the request with `error` and nothing on the stream.
- R8: The 512 data bytes appear on `m_data` in card order, with `m_last` high only with the final byte. Two more bytes are then clocked in and dropped, after which `busy` falls.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold and `sd_clk` stays low.
- R10: `start` is taken only while `busy` is low, and `busy` is high in the next cycle. `blk_addr` and `high_cap` are captured then. A `start` while `busy` is high has no effect.
- R11: `error` rises in the cycle `busy` falls on a failed request and clears when the next start is taken. A failed read leaves the card initialized, so the next request sends no reset command.
- R12: Once initialization has succeeded, each request sends exactly one command, the read, and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read a block |
| blk_addr | input | 32 | Block number to read |
| high_cap | input | 1 | 1 selects a block-addressed (high-capacity) card |
| sd_clk | output | 1 | Serial clock to the card |
| sd_cs_n | output | 1 | Card select, active low |
| sd_cmd | output | 1 | Serial command line, host to card |
| sd_dat | input | 1 | Serial data line, card to host |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Marks the final byte of a block |
| busy | output | 1 | A request is in progress |
| error | output | 1 | The last request failed |

## Verification
A new `start` request and a read still in flight can fall in the same cycle, since `start` is an ungated pulse while the stream and the serial engine keep running. The bench pulses `start` with a different address and card type in the middle of a block, while random back-pressure is stalling the stream. It then checks that the card model logged exactly one read command with the first argument, that the full first block arrived intact, and that no further command appeared once `busy` fell.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PWR, S_CMD, S_RESP, S_TOKEN, S_DATA, S_HOLD, S_CRC
  } sdr_state_e;

  typedef enum logic [1:0] {
    K_RESET, K_APP, K_OPCOND, K_READ
  } sdr_cmd_e;

  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam logic [7:0] DATA_TOKEN = 8'hFE;
endpackage

// File: rtl/sdr_crc7.sv
module sdr_crc7 #(
  parameter int W = 40
) (
  input  logic [W-1:0] data,
  output logic [6:0]   crc
);
  logic [6:0] st [0:W];
  assign st[0] = '0;

  for (genvar g = 0; g < W; g++) begin : g_step
    logic fb;
    assign fb        = data[W-1-g] ^ st[g][6];
    assign st[g+1]   = {st[g][5], st[g][4], st[g][3], st[g][2] ^ fb,
                        st[g][1], st[g][0], fb};
  end

  assign crc = st[W];
endmodule

// File: rtl/sdr_frame_gen.sv
module sdr_frame_gen
  import sdr_pkg::*;
#(
  parameter int BLK_SHIFT = 9
) (
  input  sdr_cmd_e    cmd,
  input  logic [31:0] addr,
  input  logic        hc,
  output logic [47:0] frame
);
  logic [5:0]  idx;
  logic [31:0] arg;
  logic [6:0]  crc;

  always_comb begin
    unique case (cmd)
      K_RESET:  begin idx = 6'd0;  arg = '0; end
      K_APP:    begin idx = 6'd55; arg = '0; end
      K_OPCOND: begin idx = 6'd41; arg = {1'b0, hc, 30'b0}; end
      default:  begin idx = 6'd17; arg = hc ? addr : (addr << BLK_SHIFT); end
    endcase
  end

  sdr_crc7 #(.W(40)) crc_i (
    .data ({2'b01, idx, arg}),
    .crc  (crc)
  );

  assign frame = {2'b01, idx, arg, crc, 1'b1};
endmodule

// File: rtl/sdr_byte_engine.sv
module sdr_byte_engine #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       idle,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(CLK_HALF - 1);

  logic          active;
  logic [HW-1:0] hcnt;
  logic [2:0]    bitn;
  logic [7:0]    sh_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hcnt   <= '0;
      bitn   <= '0;
      sh_tx  <= '1;
      rx     <= '1;
      sclk   <= 1'b0;
      mosi   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sh_tx  <= tx;
          mosi   <= tx[7];
          hcnt   <= '0;
          bitn   <= '0;
        end
      end else if (hcnt != H_LAST) begin
        hcnt <= hcnt + 1'b1;
      end else begin
        hcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            sh_tx <= {sh_tx[6:0], 1'b1};
            mosi  <= sh_tx[6];
          end
        end
      end
    end
  end

  assign idle = !active;
endmodule

// File: rtl/sd_block_reader.sv
module sd_block_reader
  import sdr_pkg::*;
#(
  parameter int CLK_HALF    = 2,
  parameter int BLOCK_BYTES = 512,
  parameter int RESP_BYTES  = 8,
  parameter int TOKEN_BYTES = 64,
  parameter int PWR_BYTES   = 10,
  parameter int INIT_TRIES  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] blk_addr,
  input  logic        high_cap,
  output logic        sd_clk,
  output logic        sd_cs_n,
  output logic        sd_cmd,
  input  logic        sd_dat,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  output logic        m_last,
  output logic        busy,
  output logic        error
);
  localparam int BLK_SHIFT = $clog2(BLOCK_BYTES);
  localparam int MAX_A     = (BLOCK_BYTES > TOKEN_BYTES) ? BLOCK_BYTES : TOKEN_BYTES;
  localparam int MAX_B     = (RESP_BYTES > PWR_BYTES) ? RESP_BYTES : PWR_BYTES;
  localparam int MAXC      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW        = $clog2(MAXC) + 1;
  localparam int TW        = $clog2(INIT_TRIES) + 1;
  localparam logic [CW-1:0] PWR_LAST  = CW'(PWR_BYTES - 1);
  localparam logic [CW-1:0] RESP_LAST = CW'(RESP_BYTES - 1);
  localparam logic [CW-1:0] TOK_LAST  = CW'(TOKEN_BYTES - 1);
  localparam logic [CW-1:0] BLK_LAST  = CW'(BLOCK_BYTES - 1);
  localparam logic [CW-1:0] FRM_LAST  = CW'(5);
  localparam logic [TW-1:0] TRY_LAST  = TW'(INIT_TRIES - 1);

  sdr_state_e  state;
  sdr_cmd_e    cur_cmd;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;
  logic [31:0] addr_q;
  logic        hc_q, inited, cs_n_q, err_q;
  logic        mv_q, ml_q;
  logic [7:0]  md_q;

  logic [47:0] frame;
  logic [7:0]  frame_byte, tx_byte;
  logic        need_byte, go, eng_idle, eng_done;
  logic [7:0]  eng_rx;

  sdr_frame_gen #(.BLK_SHIFT(BLK_SHIFT)) frame_i (
    .cmd   (cur_cmd),
    .addr  (addr_q),
    .hc    (hc_q),
    .frame (frame)
  );

  always_comb begin
    unique case (cnt[2:0])
      3'd0:    frame_byte = frame[47:40];
      3'd1:    frame_byte = frame[39:32];
      3'd2:    frame_byte = frame[31:24];
      3'd3:    frame_byte = frame[23:16];
      3'd4:    frame_byte = frame[15:8];
      default: frame_byte = frame[7:0];
    endcase
  end

  assign need_byte = (state != S_IDLE) && (state != S_HOLD);
  assign tx_byte   = (state == S_CMD) ? frame_byte : IDLE_BYTE;
  assign go        = need_byte && eng_idle && !eng_done;

  sdr_byte_engine #(.CLK_HALF(CLK_HALF)) eng_i (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .tx    (tx_byte),
    .miso  (sd_dat),
    .sclk  (sd_clk),
    .mosi  (sd_cmd),
    .idle  (eng_idle),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur_cmd <= K_RESET;
      cnt     <= '0;
      tries   <= '0;
      addr_q  <= '0;
      hc_q    <= 1'b0;
      inited  <= 1'b0;
      cs_n_q  <= 1'b1;
      err_q   <= 1'b0;
      mv_q    <= 1'b0;
      ml_q    <= 1'b0;
      md_q    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          addr_q <= blk_addr;
          hc_q   <= high_cap;
          err_q  <= 1'b0;
          cnt    <= '0;
          if (inited) begin
            cur_cmd <= K_READ;
            state   <= S_CMD;
          end else begin
            cs_n_q <= 1'b1;
            tries  <= '0;
            state  <= S_PWR;
          end
        end
        S_PWR: if (eng_done) begin
          if (cnt == PWR_LAST) begin
            cs_n_q  <= 1'b0;
            cur_cmd <= K_RESET;
            state   <= S_CMD;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_CMD: if (eng_done) begin
          if (cnt == FRM_LAST) begin
            state <= S_RESP;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RESP: if (eng_done) begin
          if (!eng_rx[7]) begin
            cnt <= '0;
            unique case (cur_cmd)
              K_RESET: if (eng_rx == 8'h01) begin
                cur_cmd <= K_APP;
                state   <= S_CMD;
              end else begin
                state <= S_IDLE;
                err_q <= 1'b1;
              end
              K_APP: if (eng_rx[7:1] == 7'd0) begin
                cur_cmd <= K_OPCOND;
                state   <= S_CMD;
              end else begin
                state <= S_IDLE;
                err_q <= 1'b1;
              end
              K_OPCOND: if (eng_rx == 8'h00) begin
                inited  <= 1'b1;
                cur_cmd <= K_READ;
                state   <= S_CMD;
              end else if (eng_rx == 8'h01 && tries != TRY_LAST) begin
                tries   <= tries + 1'b1;
                cur_cmd <= K_APP;
                state   <= S_CMD;
              end else begin
                state <= S_IDLE;
                err_q <= 1'b1;
              end
              default: if (eng_rx == 8'h00) begin
                state <= S_TOKEN;
              end else begin
                state <= S_IDLE;
                err_q <= 1'b1;
              end
            endcase
          end else if (cnt == RESP_LAST) begin
            state <= S_IDLE;
            err_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_TOKEN: if (eng_done) begin
          if (eng_rx == DATA_TOKEN) begin
            state <= S_DATA;
            cnt   <= '0;
          end else if (eng_rx != IDLE_BYTE || cnt == TOK_LAST) begin
            state <= S_IDLE;
            err_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (eng_done) begin
          md_q  <= eng_rx;
          mv_q  <= 1'b1;
          ml_q  <= (cnt == BLK_LAST);
          state <= S_HOLD;
        end
        S_HOLD: if (m_ready) begin
          mv_q <= 1'b0;
          ml_q <= 1'b0;
          if (cnt == BLK_LAST) begin
            state <= S_CRC;
            cnt   <= '0;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= S_DATA;
          end
        end
        S_CRC: if (eng_done) begin
          if (cnt[0]) state <= S_IDLE;
          else        cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sd_cs_n = cs_n_q;
  assign m_valid = mv_q;
  assign m_data  = md_q;
  assign m_last  = ml_q;
  assign busy    = (state != S_IDLE);
  assign error   = err_q;
endmodule

// File: rtl/sdr_reader_chk.sv
module sdr_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       error,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       sd_clk
);
  p_take_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy)
    else $error("start taken while idle did not raise busy");

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)))
    else $error("stream byte changed under back-pressure");

  p_stall_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !sd_clk)
    else $error("serial clock high while a byte waits");

  p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy)
    else $error("error flag set during a request");

  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> busy)
    else $error("stream byte offered outside a request");

  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid)
    else $error("last marker without a valid byte");

  p_clk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sd_clk)
    else $error("serial clock not idle low");
endmodule

bind sd_block_reader sdr_reader_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .error   (error),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_last  (m_last),
  .sd_clk  (sd_clk)
);

// File: tb/sd_block_reader_tb_top.sv
`timescale 1ns/1ps
module sd_block_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] blk_addr = '0;
  logic        high_cap = 1'b0;
  logic        sd_clk, sd_cs_n, sd_cmd;
  logic        sd_dat = 1'b1;
  logic        m_valid, m_last, busy, error;
  logic        m_ready = 1'b0;
  logic [7:0]  m_data;

  always #5 clk = ~clk;

  sd_block_reader #(.CLK_HALF(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .high_cap(high_cap), .sd_clk(sd_clk), .sd_cs_n(sd_cs_n),
    .sd_cmd(sd_cmd), .sd_dat(sd_dat), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .busy(busy), .error(error)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7_ref(logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [7:0] blk_byte(logic [31:0] a, int i);
    logic [8:0] ii = 9'(i);
    return (a[7:0] + a[16:9]) ^ ii[7:0] ^ (ii[8] ? 8'hA5 : 8'h3C);
  endfunction

  function automatic logic [31:0] exp_arg(logic [31:0] a, bit hc);
    return hc ? a : (a << 9);
  endfunction

  // ---------------- card model ----------------
  int ncr_fill = 1, tok_fill = 2, busy_acmd = 0, pre_clks = 0, pre_at_cmd0 = 0, crc_bad = 0;
  logic [7:0] tok_val = 8'hFE, cmd0_r1 = 8'h01;
  bit card_ready = 1'b0;
  bit dq[$];
  int log_idx[$];
  logic [31:0] log_arg[$];
  logic [7:0]  log_end[$];
  int bitc = 0, fcnt = 0;
  logic [7:0]  rxsh = '0;
  logic [47:0] fr = '0;

  task automatic push_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) dq.push_back(b[i]);
  endtask

  task automatic reply(logic [7:0] r1);
    for (int i = 0; i < ncr_fill; i++) push_byte(8'hFF);
    push_byte(r1);
  endtask

  task automatic card_cmd(logic [47:0] f);
    int idx = int'(f[45:40]);
    logic [31:0] arg = f[39:8];
    log_idx.push_back(idx);
    log_arg.push_back(arg);
    log_end.push_back(f[7:0]);
    if (crc7_ref(f[47:8]) != f[7:1] || !f[0]) begin
      crc_bad++;
      reply(8'h08);
    end else if (idx == 0) begin
      pre_at_cmd0 = pre_clks;
      card_ready = 1'b0;
      reply(cmd0_r1);
    end else if (idx == 55) begin
      reply(card_ready ? 8'h00 : 8'h01);
    end else if (idx == 41) begin
      if (busy_acmd > 0) begin busy_acmd--; reply(8'h01); end
      else begin card_ready = 1'b1; reply(8'h00); end
    end else if (idx == 17 && card_ready) begin
      reply(8'h00);
      for (int i = 0; i < tok_fill; i++) push_byte(8'hFF);
      push_byte(tok_val);
      if (tok_val == 8'hFE) begin
        for (int i = 0; i < 512; i++) push_byte(blk_byte(arg, i));
        push_byte(8'h5A);
        push_byte(8'hC3);
      end
    end else begin
      reply(8'h04);
    end
  endtask

  initial forever begin
    @(posedge sd_clk);
    if (sd_cs_n) begin
      pre_clks++;
      bitc = 0;
    end else begin
      rxsh = {rxsh[6:0], sd_cmd};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (fcnt == 0) begin
          if (rxsh[7:6] == 2'b01) begin fr = {40'b0, rxsh}; fcnt = 1; end
        end else begin
          fr = {fr[39:0], rxsh};
          fcnt++;
          if (fcnt == 6) begin fcnt = 0; card_cmd(fr); end
        end
      end
    end
  end

  initial forever begin
    @(negedge sd_clk);
    sd_dat = (dq.size() > 0) ? dq.pop_front() : 1'b1;
  end

  // ---------------- stream consumer ----------------
  int rdy_pct = 80;
  logic [7:0] got[$];
  int last_bad = 0, stall_bad = 0;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_last = 1'b0;

  initial forever begin
    @(negedge clk);
    m_ready = (($urandom % 100) < rdy_pct);
    if (prev_stall && !(m_valid && m_data == prev_data && m_last == prev_last)) stall_bad++;
    if (m_valid && sd_clk) stall_bad++;
    if (m_valid && m_ready) begin
      if (m_last != (got.size() == 511)) last_bad++;
      got.push_back(m_data);
    end
    prev_stall = m_valid && !m_ready;
    prev_data  = m_data;
    prev_last  = m_last;
  end

  // ---------------- helpers ----------------
  task automatic launch(logic [31:0] a, bit hc);
    @(negedge clk);
    got.delete();
    last_bad = 0;
    stall_bad = 0;
    blk_addr = a;
    high_cap = hc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic check_block(logic [31:0] arg, string req);
    int mism = 0;
    chk(error == 1'b0, req, "error after read", error, 0);
    chk(got.size() == 512, "R8", "byte count", got.size(), 512);
    for (int i = 0; i < got.size(); i++)
      if (got[i] != blk_byte(arg, i)) mism++;
    chk(mism == 0, "R8", "mismatched bytes", mism, 0);
    chk(last_bad == 0, "R8", "last marker errors", last_bad, 0);
    chk(stall_bad == 0, "R9", "back-pressure violations", stall_bad, 0);
    chk(log_idx[log_idx.size()-1] == 17, "R5", "read index", log_idx[log_idx.size()-1], 17);
    chk(log_arg[log_arg.size()-1] == arg, "R5", "read argument", log_arg[log_arg.size()-1], arg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    dq.delete();
    fcnt = 0;
    card_ready = 1'b0;
    pre_clks = 0;
    log_idx.delete();
    log_arg.delete();
    log_end.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int sz;
    logic [31:0] a;
    bit hc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !error && !m_valid, "R1", "status after reset", {busy, error, m_valid}, 0);
    chk(sd_cs_n && sd_cmd && !sd_clk, "R1", "pins after reset", {sd_cs_n, sd_cmd, sd_clk}, 3'b110);

    // first read: initialization then standard-capacity read
    launch(32'd5, 1'b0);
    wait_idle();
    chk(log_idx.size() == 4, "R4", "init command count", log_idx.size(), 4);
    chk(log_idx[0] == 0 && log_idx[1] == 55 && log_idx[2] == 41, "R4", "init order",
        {log_idx[0], log_idx[1], log_idx[2]}, {32'd0, 32'd55, 32'd41});
    chk(log_arg[2][30] == 1'b0, "R4", "capacity bit standard", log_arg[2][30], 0);
    chk(pre_at_cmd0 >= 74, "R4", "idle clocks before reset cmd", pre_at_cmd0, 80);
    chk(log_end[0] == 8'h95, "R3", "reset cmd last byte", log_end[0], 8'h95);
    chk(crc_bad == 0, "R3", "frames with bad CRC", crc_bad, 0);
    chk(!sd_clk && sd_cmd, "R2", "idle line levels", {sd_clk, sd_cmd}, 1);
    check_block(exp_arg(32'd5, 1'b0), "R2");

    // random reads with back-pressure, no re-initialization
    rdy_pct = 55;
    for (int k = 0; k < 3; k++) begin
      a = $urandom;
      hc = 1'($urandom);
      sz = log_idx.size();
      launch(a, hc);
      wait_idle();
      chk(log_idx.size() == sz + 1, "R12", "commands per read", log_idx.size() - sz, 1);
      check_block(exp_arg(a, hc), "R5");
    end
    rdy_pct = 80;

    // start during busy is ignored
    sz = log_idx.size();
    launch(32'h0000_1234, 1'b1);
    while (got.size() < 100) @(negedge clk);
    blk_addr = 32'h0BAD_0BAD;
    high_cap = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check_block(32'h0000_1234, "R10");
    repeat (300) @(negedge clk);
    chk(log_idx.size() == sz + 1, "R10", "commands after ignored start", log_idx.size() - sz, 1);
    chk(busy == 1'b0, "R10", "busy after ignored start", busy, 0);

    // reply hunt limit: 8 filler bytes fail
    ncr_fill = 8;
    sz = log_idx.size();
    launch(32'd77, 1'b0);
    wait_idle();
    chk(error == 1'b1, "R6", "error on late reply", error, 1);
    chk(got.size() == 0, "R6", "bytes after late reply", got.size(), 0);
    dq.delete();
    // 7 filler bytes still succeed; error clears, no re-init
    ncr_fill = 7;
    launch(32'd78, 1'b0);
    chk(error == 1'b0, "R11", "error cleared on start", error, 0);
    wait_idle();
    chk(log_idx.size() == sz + 2 && log_idx[sz+1] == 17, "R11", "no re-init after failure",
        log_idx.size() - sz, 2);
    check_block(exp_arg(32'd78, 1'b0), "R6");
    ncr_fill = 1;

    // bad data token
    tok_val = 8'h05;
    launch(32'd9, 1'b1);
    wait_idle();
    chk(error == 1'b1, "R7", "error on bad token", error, 1);
    chk(got.size() == 0, "R7", "bytes after bad token", got.size(), 0);
    dq.delete();
    tok_val = 8'hFE;

    // address wrap for standard capacity
    a = 32'h0080_0003;
    launch(a, 1'b0);
    wait_idle();
    check_block(32'h0000_0600, "R5");

    // failed initialization, then high-capacity init with retries
    do_reset();
    cmd0_r1 = 8'h05;
    launch(32'd1, 1'b1);
    wait_idle();
    chk(error == 1'b1, "R4", "error on bad reset reply", error, 1);
    chk(log_idx.size() == 1, "R4", "commands on failed init", log_idx.size(), 1);
    dq.delete();
    cmd0_r1 = 8'h01;
    busy_acmd = 3;
    launch(32'hFFFF_FFFF, 1'b1);
    wait_idle();
    begin
      int n41 = 0, hcs_bad = 0;
      for (int i = 1; i < log_idx.size(); i++)
        if (log_idx[i] == 41) begin
          n41++;
          if (!log_arg[i][30]) hcs_bad++;
        end
      chk(log_idx[1] == 0, "R11", "re-init after failed init", log_idx[1], 0);
      chk(n41 == 4, "R4", "opcond attempts", n41, 4);
      chk(hcs_bad == 0, "R4", "capacity bit high", hcs_bad, 0);
    end
    check_block(32'hFFFF_FFFF, "R5");
    chk(crc_bad == 0, "R3", "frames with bad CRC", crc_bad, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule